// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block carries out the stack-related control transfers of a small CPU with an 8-bit data path and a 16-bit program counter. It runs direct calls, short calls into a fixed upper page, calls through a vector table, software breaks and the three kinds of return. It also runs register-pair and flag-byte pushes and pops, and it loads and reads the stack pointer. The CPU's decode stage hands over an operation code together with its operands, the current PC and flag byte (PSW). The sequencer then walks through the operation one step per clock over a byte-wide memory port and reports the new PC, SP, PSW and AX values with a one-cycle `done` pulse.

The stack pointer, the flag byte written back, the NMI-in-service flag and the AX result are held inside the block. The interrupt-enable flag is bit 7 of the held flag byte. Each operation has its own schedule of memory accesses and a fixed length, so the CPU can count on a known latency.

Top module: `callstack_seq`

## Requirements
- R1: While reset is asserted and after it is released, sp_out is 0xFEFF; ie, nmis, done, mem_en, pc_out, psw_out and ax_out are all 0.
- R2: A command is accepted on a clock edge where start is 1 and the block is idle. Step 1 is the next cycle, and done is high only in the last step. The number of steps per op code is: 0 call 7, 1 short call 5, 2 table call 6, 3 break 6, 4 return 6, 5 interrupt return 6, 6 break return 6, 7 pair push 4, 8 pair pop 4, 9 flag push 2, 10 flag pop 2, 11 SP load 2, 12 SP read 2. New state is visible in the cycle after done.
- R3: The port makes at most one byte access per cycle, and only while busy. Read data is taken from mem_rdata in the cycle after the read address is issued. Steps not listed for an op make no access.
- R4: A call (op 0) writes (PC+3)[15:8] to SP-1 in step 1 and (PC+3)[7:0] to SP-2 in step 2, then loads PC with tgt16. A short call (op 1) does the same with PC+2 and loads PC with {5'b00001, tgt11}. Both lower SP by 2.
- R5: A table call (op 2) pushes PC+1 as in R4. It then reads the zero-extended tidx in step 3 as the new PC low byte and tidx+1 in step 4 as the high byte, and lowers SP by 2.
- R6: A break (op 3) writes psw_in to SP-1, (PC+1)[15:8] to SP-2 and (PC+1)[7:0] to SP-3 in steps 1 to 3. It reads 0x003E (PC low) in step 4 and 0x003F (PC high) in step 5. SP drops by 3 and psw_out becomes psw_in with bit 7 cleared, so ie is 0.
- R7: A return (op 4) reads SP in step 1 (PC low) and SP+1 in step 2 (PC high), and raises SP by 2.
- R8: Interrupt return (op 5) and break return (op 6) also read SP+2 in step 3 into psw_out, with ie taken from bit 7, and raise SP by 3. Op 5 clears nmis; op 6 leaves it unchanged.
- R9: A pair push (op 7) writes word[15:8] to SP-1 in step 1 and word[7:0] to SP-2 in step 2, lowering SP by 2. A pair pop (op 8) reads SP (low) in step 1 and SP+1 (high) in step 2 into ax_out, raising SP by 2.
- R10: A flag push (op 9) writes psw_in to SP-1 in step 1 and lowers SP by 1. A flag pop (op 10) reads SP in step 1 into psw_out and raises SP by 1.
- R11: Op 11 loads SP from word and op 12 copies SP into ax_out, with no memory access. Ops other than calls, breaks and returns leave pc_out unchanged.
- R12: All SP, address and return-address arithmetic wraps modulo 2^16.
- R13: start is ignored while busy: the running operation's accesses and results are unchanged, and no command follows it.
- R14: A 1 on nmi_enter while idle sets nmis from the next cycle. While busy it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| op | input | 4 | Operation code (R2) |
| tgt16 | input | 16 | Call target |
| tgt11 | input | 11 | Short-call offset |
| tidx | input | 5 | Table index |
| word | input | 16 | Pair to push, or SP load value |
| pc_in | input | 16 | PC of the current instruction |
| psw_in | input | 8 | Current flag byte |
| nmi_enter | input | 1 | Sets the NMI-in-service flag |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | Last step of an operation |
| pc_out | output | 16 | Updated PC |
| sp_out | output | 16 | Stack pointer |
| psw_out | output | 8 | Flag byte to write back |
| ie | output | 1 | Interrupt enable (bit 7 of psw_out) |
| nmis | output | 1 | NMI-in-service flag |
| ax_out | output | 16 | Popped pair or copied SP |

## Verification
The assertions assume a memory that answers every read in the following cycle. They also assume the CPU raises start only on defined op codes, since codes 13 to 15 only use up two idle steps. The bench keeps the stack and table areas apart, so no write in an operation lands on a byte that the same operation reads. It also issues each command only from an idle cycle, except for the deliberate strobe during a busy break return that tests that start and nmi_enter are ignored.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam int unsigned SW = 3;

  typedef enum logic [3:0] {
    OP_CALL    = 4'd0,
    OP_CALLF   = 4'd1,
    OP_CALLT   = 4'd2,
    OP_BRK     = 4'd3,
    OP_RET     = 4'd4,
    OP_RETI    = 4'd5,
    OP_RETB    = 4'd6,
    OP_PUSHRP  = 4'd7,
    OP_POPRP   = 4'd8,
    OP_PUSHPSW = 4'd9,
    OP_POPPSW  = 4'd10,
    OP_SPLD    = 4'd11,
    OP_SPRD    = 4'd12,
    OP_NOP13   = 4'd13,
    OP_NOP14   = 4'd14,
    OP_NOP15   = 4'd15
  } op_e;

  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_WR = 2'd1, ACC_RD = 2'd2} acc_e;
  typedef enum logic [1:0] {BASE_SP = 2'd0, BASE_TBL = 2'd1, BASE_VEC = 2'd2} base_e;
  typedef enum logic [2:0] {
    BY_RETH = 3'd0, BY_RETL = 3'd1, BY_PSW = 3'd2, BY_RPH = 3'd3,
    BY_RPL = 3'd4, BY_PCL = 3'd5, BY_PCH = 3'd6
  } byte_e;

  typedef struct packed {
    acc_e             acc;
    base_e            base;
    logic signed [2:0] off;
    byte_e            sel;
  } ustep_t;

  function automatic ustep_t mk(acc_e a, base_e b, logic signed [2:0] o, byte_e s);
    ustep_t u;
    u.acc  = a;
    u.base = b;
    u.off  = o;
    u.sel  = s;
    return u;
  endfunction
endpackage

// File: rtl/cs_ucode.sv
module cs_ucode
  import cs_pkg::*;
(
  input  op_e               op,
  input  logic [SW-1:0]     step,
  output ustep_t            us,
  output logic [SW-1:0]     len
);
  always_comb begin
    us  = mk(ACC_NONE, BASE_SP, 3'sd0, BY_RETH);
    len = SW'(2);
    unique case (op)
      OP_CALL, OP_CALLF, OP_CALLT: begin
        len = (op == OP_CALL) ? SW'(7) : (op == OP_CALLF) ? SW'(5) : SW'(6);
        case (step)
          SW'(1): us = mk(ACC_WR, BASE_SP, -3'sd1, BY_RETH);
          SW'(2): us = mk(ACC_WR, BASE_SP, -3'sd2, BY_RETL);
          SW'(3): if (op == OP_CALLT) us = mk(ACC_RD, BASE_TBL, 3'sd0, BY_PCL);
          SW'(4): if (op == OP_CALLT) us = mk(ACC_RD, BASE_TBL, 3'sd1, BY_PCH);
          default: ;
        endcase
      end
      OP_BRK: begin
        len = SW'(6);
        case (step)
          SW'(1): us = mk(ACC_WR, BASE_SP, -3'sd1, BY_PSW);
          SW'(2): us = mk(ACC_WR, BASE_SP, -3'sd2, BY_RETH);
          SW'(3): us = mk(ACC_WR, BASE_SP, -3'sd3, BY_RETL);
          SW'(4): us = mk(ACC_RD, BASE_VEC, 3'sd0, BY_PCL);
          SW'(5): us = mk(ACC_RD, BASE_VEC, 3'sd1, BY_PCH);
          default: ;
        endcase
      end
      OP_RET, OP_RETI, OP_RETB: begin
        len = SW'(6);
        case (step)
          SW'(1): us = mk(ACC_RD, BASE_SP, 3'sd0, BY_PCL);
          SW'(2): us = mk(ACC_RD, BASE_SP, 3'sd1, BY_PCH);
          SW'(3): if (op != OP_RET) us = mk(ACC_RD, BASE_SP, 3'sd2, BY_PSW);
          default: ;
        endcase
      end
      OP_PUSHRP: begin
        len = SW'(4);
        if (step == SW'(1)) us = mk(ACC_WR, BASE_SP, -3'sd1, BY_RPH);
        else if (step == SW'(2)) us = mk(ACC_WR, BASE_SP, -3'sd2, BY_RPL);
      end
      OP_POPRP: begin
        len = SW'(4);
        if (step == SW'(1)) us = mk(ACC_RD, BASE_SP, 3'sd0, BY_RPL);
        else if (step == SW'(2)) us = mk(ACC_RD, BASE_SP, 3'sd1, BY_RPH);
      end
      OP_PUSHPSW: if (step == SW'(1)) us = mk(ACC_WR, BASE_SP, -3'sd1, BY_PSW);
      OP_POPPSW:  if (step == SW'(1)) us = mk(ACC_RD, BASE_SP, 3'sd0, BY_PSW);
      default: ;
    endcase
  end
endmodule

// File: rtl/cs_port.sv
module cs_port
  import cs_pkg::*;
#(
  parameter int unsigned      TW  = 5,
  parameter logic [AW-1:0]    VEC = 16'h003E
) (
  input  logic              active,
  input  ustep_t            us,
  input  logic [AW-1:0]     sp,
  input  logic [TW-1:0]     tidx,
  input  logic [AW-1:0]     ret,
  input  logic [DW-1:0]     psw,
  input  logic [AW-1:0]     pair,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata
);
  logic [AW-1:0] base;
  logic [AW-1:0] off_ext;

  always_comb begin
    unique case (us.base)
      BASE_TBL: base = {{(AW-TW){1'b0}}, tidx};
      BASE_VEC: base = VEC;
      default:  base = sp;
    endcase
    off_ext  = {{(AW-3){us.off[2]}}, us.off};
    mem_addr = base + off_ext;
    unique case (us.sel)
      BY_RETH: mem_wdata = ret[AW-1:DW];
      BY_RETL: mem_wdata = ret[DW-1:0];
      BY_RPH:  mem_wdata = pair[AW-1:DW];
      BY_RPL:  mem_wdata = pair[DW-1:0];
      default: mem_wdata = psw;
    endcase
    mem_en = active && (us.acc != ACC_NONE);
    mem_we = active && (us.acc == ACC_WR);
  end
endmodule

// File: rtl/cs_capture.sv
module cs_capture
  import cs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_rd,
  input  byte_e         sel,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] pcl_n,
  output logic [DW-1:0] pch_n,
  output logic [DW-1:0] psw_n,
  output logic [DW-1:0] rpl_n,
  output logic [DW-1:0] rph_n
);
  logic          pend_q;
  byte_e         psel_q, psel_d;
  logic [DW-1:0] pcl_q, pch_q, psw_q, rpl_q, rph_q;

  always_comb begin
    psel_d = issue_rd ? sel : psel_q;
    pcl_n = pcl_q;
    pch_n = pch_q;
    psw_n = psw_q;
    rpl_n = rpl_q;
    rph_n = rph_q;
    if (pend_q) begin
      case (psel_q)
        BY_PCL: pcl_n = rdata;
        BY_PCH: pch_n = rdata;
        BY_PSW: psw_n = rdata;
        BY_RPL: rpl_n = rdata;
        BY_RPH: rph_n = rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      psel_q <= BY_PCL;
      pcl_q  <= '0;
      pch_q  <= '0;
      psw_q  <= '0;
      rpl_q  <= '0;
      rph_q  <= '0;
    end else begin
      pend_q <= issue_rd;
      psel_q <= psel_d;
      if (pend_q) begin
        pcl_q <= pcl_n;
        pch_q <= pch_n;
        psw_q <= psw_n;
        rpl_q <= rpl_n;
        rph_q <= rph_n;
      end
    end
  end
endmodule

// File: rtl/callstack_seq.sv
module callstack_seq
  import cs_pkg::*;
#(
  parameter logic [AW-1:0] SP_RESET   = 16'hFEFF,
  parameter logic [AW-1:0] BRK_VEC    = 16'h003E,
  parameter logic [4:0]    SHORT_PAGE = 5'b00001,
  parameter int unsigned   IE_BIT     = 7,
  parameter int unsigned   TW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [15:0]   tgt16,
  input  logic [10:0]   tgt11,
  input  logic [4:0]    tidx,
  input  logic [15:0]   word,
  input  logic [15:0]   pc_in,
  input  logic [7:0]    psw_in,
  input  logic          nmi_enter,
  input  logic [7:0]    mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          done,
  output logic [15:0]   pc_out,
  output logic [15:0]   sp_out,
  output logic [7:0]    psw_out,
  output logic          ie,
  output logic          nmis,
  output logic [15:0]   ax_out
);
  localparam int unsigned SHW = AW - 5;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  // sequencing state and latched operands
  logic          busy_q, busy_d;
  logic [SW-1:0] step_q, step_d, len;
  op_e           op_q;
  logic [AW-1:0] a16_q, word_q, ret_q, ret_d;
  logic [SHW-1:0] a11_q;
  logic [TW-1:0] tidx_q;
  logic [DW-1:0] psw_lat_q;
  logic          accept;
  ustep_t        us;

  // architectural results
  logic [AW-1:0] pc_q, pc_d, sp_q, sp_d, ax_q, ax_d;
  logic [DW-1:0] psw_q, psw_d;
  logic          nmis_q, nmis_d;
  logic [DW-1:0] pcl_n, pch_n, pswr_n, rpl_n, rph_n;

  assign accept = start && !busy_q;
  assign done   = busy_q && (step_q == len);

  cs_ucode u_ucode (.op(op_q), .step(step_q), .us(us), .len(len));

  cs_port #(.TW(TW), .VEC(BRK_VEC)) u_port (
    .active(busy_q), .us(us), .sp(sp_q), .tidx(tidx_q), .ret(ret_q),
    .psw(psw_lat_q), .pair(word_q), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  cs_capture u_cap (
    .clk(clk), .rst_n(rst_s), .issue_rd(busy_q && (us.acc == ACC_RD)),
    .sel(us.sel), .rdata(mem_rdata), .pcl_n(pcl_n), .pch_n(pch_n),
    .psw_n(pswr_n), .rpl_n(rpl_n), .rph_n(rph_n)
  );

  always_comb begin
    unique case (op_e'(op))
      OP_CALL:  ret_d = pc_in + 16'd3;
      OP_CALLF: ret_d = pc_in + 16'd2;
      default:  ret_d = pc_in + 16'd1;
    endcase
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    if (accept) begin
      busy_d = 1'b1;
      step_d = SW'(1);
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      step_d = step_q + SW'(1);
    end

    pc_d   = pc_q;
    sp_d   = sp_q;
    psw_d  = psw_q;
    ax_d   = ax_q;
    nmis_d = nmis_q;
    if (!busy_q && nmi_enter) nmis_d = 1'b1;
    if (done) begin
      case (op_q)
        OP_CALL:   begin pc_d = a16_q;               sp_d = sp_q - 16'd2; end
        OP_CALLF:  begin pc_d = {SHORT_PAGE, a11_q}; sp_d = sp_q - 16'd2; end
        OP_CALLT:  begin pc_d = {pch_n, pcl_n};      sp_d = sp_q - 16'd2; end
        OP_BRK: begin
          pc_d = {pch_n, pcl_n};
          sp_d = sp_q - 16'd3;
          psw_d = psw_lat_q;
          psw_d[IE_BIT] = 1'b0;
        end
        OP_RET:    begin pc_d = {pch_n, pcl_n};      sp_d = sp_q + 16'd2; end
        OP_RETI:   begin pc_d = {pch_n, pcl_n}; psw_d = pswr_n; sp_d = sp_q + 16'd3; nmis_d = 1'b0; end
        OP_RETB:   begin pc_d = {pch_n, pcl_n}; psw_d = pswr_n; sp_d = sp_q + 16'd3; end
        OP_PUSHRP: sp_d = sp_q - 16'd2;
        OP_POPRP:  begin ax_d = {rph_n, rpl_n};      sp_d = sp_q + 16'd2; end
        OP_PUSHPSW: sp_d = sp_q - 16'd1;
        OP_POPPSW: begin psw_d = pswr_n;             sp_d = sp_q + 16'd1; end
        OP_SPLD:   sp_d = word_q;
        OP_SPRD:   ax_d = sp_q;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q    <= 1'b0;
      step_q    <= '0;
      op_q      <= OP_NOP15;
      a16_q     <= '0;
      a11_q     <= '0;
      tidx_q    <= '0;
      word_q    <= '0;
      ret_q     <= '0;
      psw_lat_q <= '0;
      pc_q      <= '0;
      sp_q      <= SP_RESET;
      psw_q     <= '0;
      ax_q      <= '0;
      nmis_q    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      if (accept) begin
        op_q      <= op_e'(op);
        a16_q     <= tgt16;
        a11_q     <= tgt11;
        tidx_q    <= tidx;
        word_q    <= word;
        ret_q     <= ret_d;
        psw_lat_q <= psw_in;
      end
      if (done) begin
        pc_q  <= pc_d;
        sp_q  <= sp_d;
        psw_q <= psw_d;
        ax_q  <= ax_d;
      end
      nmis_q <= nmis_d;
    end
  end

  assign pc_out  = pc_q;
  assign sp_out  = sp_q;
  assign psw_out = psw_q;
  assign ie      = psw_q[IE_BIT];
  assign nmis    = nmis_q;
  assign ax_out  = ax_q;

  logic [AW-1:0] wr_gap;
  assign wr_gap = sp_q - mem_addr;

  // R3
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> mem_en);
  // R3
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !busy_q |-> !mem_en);
  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R4
  write_window_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> (wr_gap >= 16'd1 && wr_gap <= 16'd3));
  // R10
  psw_push_sp_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && op_q == OP_PUSHPSW) |=> (sp_q == $past(sp_q) - 16'd1));
  // R8
  reti_clears_nmis_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && op_q == OP_RETI) |=> !nmis);
  // R6
  brk_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && op_q == OP_BRK) |=> !ie);
  // R13
  busy_holds_op_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && !done) |=> $stable(op_q));
endmodule

// File: tb/callstack_seq_test.sv
`timescale 1ns/1ps
module callstack_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, nmi_enter = 1'b0;
  logic [3:0] op = '0;
  logic [15:0] tgt16 = '0, word = '0, pc_in = '0;
  logic [10:0] tgt11 = '0;
  logic [4:0] tidx = '0;
  logic [7:0] psw_in = '0, mem_rdata = '0;
  logic mem_en, mem_we, done, ie, nmis;
  logic [15:0] mem_addr, pc_out, sp_out, ax_out;
  logic [7:0] mem_wdata, psw_out;

  callstack_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tgt16(tgt16), .tgt11(tgt11),
    .tidx(tidx), .word(word), .pc_in(pc_in), .psw_in(psw_in), .nmi_enter(nmi_enter),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .pc_out(pc_out), .sp_out(sp_out),
    .psw_out(psw_out), .ie(ie), .nmis(nmis), .ax_out(ax_out)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int miscmp = 0;

  logic [7:0] bmem [int unsigned];
  function automatic logic [7:0] peek(logic [15:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
      else        mem_rdata <= peek(mem_addr);
    end
  end

  typedef struct { bit en; bit we; logic [15:0] a; logic [7:0] d; } acc_t;
  acc_t q[$];
  logic [15:0] e_pc = '0, e_sp = 16'hFEFF, e_ax = '0;
  logic [7:0]  e_psw = '0;
  bit          e_nmis = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(logic [15:0] a, logic [7:0] d);
    acc_t x; x.en = 1; x.we = 1; x.a = a; x.d = d; q.push_back(x);
  endtask
  task automatic rq(logic [15:0] a);
    acc_t x; x.en = 1; x.we = 0; x.a = a; x.d = '0; q.push_back(x);
  endtask
  task automatic nq();
    acc_t x; x.en = 0; x.we = 0; x.a = '0; x.d = '0; q.push_back(x);
  endtask

  task automatic check_state(string req);
    chk(req, "done idle", done, 0);
    chk(req, "mem_en idle", mem_en, 0);
    chk(req, "pc_out", pc_out, e_pc);
    chk(req, "sp_out", sp_out, e_sp);
    chk(req, "psw_out", psw_out, e_psw);
    chk(req, "ie", ie, e_psw[7]);
    chk(req, "nmis", nmis, e_nmis);
    chk(req, "ax_out", ax_out, e_ax);
  endtask

  // Build the expected step list from the requirements, run, compare every cycle.
  task automatic run(logic [3:0] o, string req, bit poke);
    logic [15:0] ret, s0, t0;
    int len;
    q.delete();
    s0 = e_sp;
    t0 = {11'd0, tidx};
    len = 2;
    case (o)
      4'd0, 4'd1, 4'd2: begin // R4 R5
        ret = pc_in + ((o == 0) ? 16'd3 : (o == 1) ? 16'd2 : 16'd1);
        wq(s0 - 16'd1, ret[15:8]); wq(s0 - 16'd2, ret[7:0]);
        e_sp = s0 - 16'd2;
        if (o == 0) begin len = 7; e_pc = tgt16; end
        else if (o == 1) begin len = 5; e_pc = {5'b00001, tgt11}; end
        else begin
          len = 6; rq(t0); rq(t0 + 16'd1);
          e_pc = {peek(t0 + 16'd1), peek(t0)};
        end
      end
      4'd3: begin // R6
        ret = pc_in + 16'd1; len = 6;
        wq(s0 - 16'd1, psw_in); wq(s0 - 16'd2, ret[15:8]); wq(s0 - 16'd3, ret[7:0]);
        rq(16'h003E); rq(16'h003F);
        e_pc = {peek(16'h003F), peek(16'h003E)};
        e_psw = psw_in & 8'h7F; e_sp = s0 - 16'd3;
      end
      4'd4, 4'd5, 4'd6: begin // R7 R8
        len = 6; rq(s0); rq(s0 + 16'd1);
        e_pc = {peek(s0 + 16'd1), peek(s0)};
        if (o == 4) e_sp = s0 + 16'd2;
        else begin
          rq(s0 + 16'd2); e_psw = peek(s0 + 16'd2); e_sp = s0 + 16'd3;
          if (o == 5) e_nmis = 1'b0;
        end
      end
      4'd7: begin len = 4; wq(s0 - 16'd1, word[15:8]); wq(s0 - 16'd2, word[7:0]); e_sp = s0 - 16'd2; end // R9
      4'd8: begin len = 4; rq(s0); rq(s0 + 16'd1); e_ax = {peek(s0 + 16'd1), peek(s0)}; e_sp = s0 + 16'd2; end // R9
      4'd9: begin wq(s0 - 16'd1, psw_in); e_sp = s0 - 16'd1; end   // R10
      4'd10: begin rq(s0); e_psw = peek(s0); e_sp = s0 + 16'd1; end // R10
      4'd11: e_sp = word; // R11
      4'd12: e_ax = s0;   // R11
      default: ;
    endcase
    while (q.size() < len) nq();

    start = 1'b1; op = o;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (poke && i == 1) begin start = 1'b1; op = 4'd9; nmi_enter = 1'b1; end // R13 R14
      if (poke && i == 2) begin start = 1'b0; op = o; nmi_enter = 1'b0; end
      chk(req, "mem_en (R3)", mem_en, q[i].en);
      if (q[i].en) begin
        chk(req, "mem_we (R3)", mem_we, q[i].we);
        chk(req, "mem_addr", mem_addr, q[i].a);
        if (q[i].we) chk(req, "mem_wdata", mem_wdata, q[i].d);
      end
      chk(req, "done (R2)", done, (i == len - 1));
      @(negedge clk);
    end
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after release");

    word = 16'h1234; run(4'd7, "R9 push pair", 0);
    psw_in = 8'hA5; run(4'd9, "R10 push psw", 0);
    psw_in = 8'h00; run(4'd10, "R10 pop psw", 0);
    run(4'd8, "R9 pop pair R11 pc kept", 0);

    pc_in = 16'h1000; tgt16 = 16'h2345; run(4'd0, "R4 call", 0);
    run(4'd4, "R7 return", 0);
    pc_in = 16'h4000; tgt11 = 11'h7AB; run(4'd1, "R4 short call", 0);
    run(4'd4, "R7 return short", 0);
    pc_in = 16'h0200; tidx = 5'd5; run(4'd2, "R5 table call", 0);
    run(4'd4, "R7 return table", 0);

    nmi_enter = 1'b1; @(negedge clk); nmi_enter = 1'b0; e_nmis = 1'b1;
    check_state("R14 nmi set");

    pc_in = 16'h3000; psw_in = 8'hC3; run(4'd3, "R6 break", 0);
    run(4'd6, "R8 break return R13 R14 ignored", 1);
    pc_in = 16'h3100; psw_in = 8'h81; run(4'd3, "R6 break again", 0);
    run(4'd5, "R8 interrupt return", 0);

    word = 16'h0001; run(4'd11, "R11 load sp", 0);
    word = 16'hABCD; run(4'd7, "R12 push wraps", 0);
    run(4'd12, "R11 read sp", 0);
    run(4'd4, "R12 return wraps", 0);
    pc_in = 16'hFFFE; tgt16 = 16'h0800; run(4'd0, "R12 call ret wraps", 0);
    run(4'd4, "R12 return to wrapped", 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule